// File: doc/BRIEF.md
# LCD Vertical Frame Timing Sequencer

This block produces the vertical timing of an LCD frame. It counts in line periods, and one line period is marked by a one-cycle `line_tick` strobe from the horizontal timing logic. Each frame passes through four phases in a fixed order: a programmable lead-in wait, the active lines, a programmable tail wait, and a sync interval. For every line period the block reports whether pixel data may be sent, which line is current, and the level of the frame clock / VSYNC output. It also gives one-cycle markers for the first active line and for the completion of the last active line.

Two panel disciplines are supported. In active mode the frame clock works as a VSYNC pulse that follows the tail wait. In passive mode both waits are forced to zero, the frame clock is high during the first line of each frame, and the sync-width field only sets how many extra blank line periods follow the active lines. Configuration is latched at each frame boundary and, while the block is disabled, on every cycle. A frame that is already running therefore never mixes old and new settings.

Top module: `lcd_vframe_seq`

## Requirements
- R1: In active mode (`act_mode`=1) each frame lasts `bwait` + (`lines`+1) + `ewait` + (`sync_width`+1) line periods, with the phases in exactly that order: lead-in wait, active lines, tail wait, sync. The sequence then repeats while `en` stays high.
- R2: A `bwait` or `ewait` value of zero removes that wait entirely, so no line period is spent in it.
- R3: `line_valid` is high during the active lines only. While it is high, `line_idx` counts 0, 1, ... `lines` from the first active line. While it is low, `line_idx` is 0.
- R4: In active mode `frame_clk` is high during the (`sync_width`+1) sync line periods and low in every other phase.
- R5: In passive mode (`act_mode`=0) `bwait` and `ewait` are ignored. `frame_clk` is high only during active line 0. The (`sync_width`+1) line periods after the last active line are blank, with `frame_clk` low.
- R6: `sof` is high for exactly one clock, in the first cycle of active line 0 of each frame.
- R7: `eof` is high for exactly one clock, in the cycle after the `line_tick` that ends the last active line, and `line_valid` is low in that cycle.
- R8: Configuration inputs are captured only at the tick that closes a frame's sync interval, or while `en` is low. A change during a frame takes effect from the next frame.
- R9: One clock after `en` goes low, `frame_clk`, `line_valid`, `sof` and `eof` are all low. On re-enable a new frame begins at its first line period with the present configuration.
- R10: Without a `line_tick` the sequencer holds its phase and line index.
- R11: During reset all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low parks the sequencer at the frame start |
| line_tick | input | 1 | One-cycle strobe marking the end of a line period |
| act_mode | input | 1 | 1 = active panel timing, 0 = passive |
| bwait | input | WAIT_W | Lead-in wait in line periods |
| ewait | input | WAIT_W | Tail wait in line periods |
| sync_width | input | SYNC_W | Sync interval length minus one |
| lines | input | LINE_W | Active line count minus one |
| frame_clk | output | 1 | Frame clock / VSYNC level |
| line_valid | output | 1 | Current line period carries pixels |
| line_idx | output | LINE_W | Index of the current active line |
| sof | output | 1 | Start-of-frame pulse |
| eof | output | 1 | End-of-active-lines pulse |

## Verification
The hardest state to reach from the ports is the frame boundary while a new configuration is pending. At that point the inputs already differ from the settings of the frame still running, and the next phase has to be chosen from the new lead-in value while the running frame keeps the old lengths. The bench starts a frame, rewrites every field right after the first line period, and then walks both frames tick by tick against a model of each one. It also drops `en` during the active-mode sync interval, so that a high `frame_clk` has to fall, and it holds `line_tick` low in the middle of the active lines.

// File: rtl/lcd_vframe_pkg.sv
package lcd_vframe_pkg;

    // Phase order within one frame; the sequencer walks them in this order.
    typedef enum logic [1:0] {
        PH_LEAD  = 2'd0,
        PH_LINES = 2'd1,
        PH_TAIL  = 2'd2,
        PH_SYNC  = 2'd3
    } vphase_e;

endpackage

// File: rtl/lcd_vframe_cfg.sv
// Shadow copy of the frame configuration plus mode resolution.
module lcd_vframe_cfg #(
    parameter int WAIT_W = 8,
    parameter int SYNC_W = 6,
    parameter int LINE_W = 10,
    parameter int CNT_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              act_mode_i,
    input  logic [WAIT_W-1:0] bwait_i,
    input  logic [WAIT_W-1:0] ewait_i,
    input  logic [SYNC_W-1:0] sync_i,
    input  logic [LINE_W-1:0] lines_i,
    output logic              live_lead_zero_o,
    output logic              act_mode_o,
    output logic              lead_zero_o,
    output logic              tail_zero_o,
    output logic [CNT_W-1:0]  lead_last_o,
    output logic [CNT_W-1:0]  tail_last_o,
    output logic [CNT_W-1:0]  sync_last_o,
    output logic [CNT_W-1:0]  lines_last_o
);

    typedef struct packed {
        logic              act;
        logic [WAIT_W-1:0] lead;
        logic [WAIT_W-1:0] tail;
        logic [SYNC_W-1:0] sync;
        logic [LINE_W-1:0] lines;
    } shadow_t;

    shadow_t sh_d, sh_q;
    logic [WAIT_W-1:0] lead_eff;
    logic [WAIT_W-1:0] tail_eff;

    always_comb begin
        sh_d = sh_q;
        if (load_i) begin
            sh_d.act   = act_mode_i;
            sh_d.lead  = bwait_i;
            sh_d.tail  = ewait_i;
            sh_d.sync  = sync_i;
            sh_d.lines = lines_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    // Passive panels never spend line periods in the waits.
    always_comb begin
        lead_eff = sh_q.act ? sh_q.lead : '0;
        tail_eff = sh_q.act ? sh_q.tail : '0;
    end

    assign live_lead_zero_o = !(act_mode_i && (|bwait_i));
    assign act_mode_o       = sh_q.act;
    assign lead_zero_o      = (lead_eff == '0);
    assign tail_zero_o      = (tail_eff == '0);
    assign lead_last_o      = CNT_W'(lead_eff) - CNT_W'(1);
    assign tail_last_o      = CNT_W'(tail_eff) - CNT_W'(1);
    assign sync_last_o      = CNT_W'(sh_q.sync);
    assign lines_last_o     = CNT_W'(sh_q.lines);

endmodule

// File: rtl/lcd_vframe_ctrl.sv
// Phase and line-period counter of the vertical sequencer.
module lcd_vframe_ctrl
    import lcd_vframe_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             tick_i,
    input  logic             live_lead_zero_i,
    input  logic             lead_zero_i,
    input  logic             tail_zero_i,
    input  logic [CNT_W-1:0] lead_last_i,
    input  logic [CNT_W-1:0] tail_last_i,
    input  logic [CNT_W-1:0] sync_last_i,
    input  logic [CNT_W-1:0] lines_last_i,
    output vphase_e          phase_o,
    output logic [CNT_W-1:0] cnt_o,
    output vphase_e          phase_nxt_o,
    output logic [CNT_W-1:0] cnt_nxt_o,
    output logic             load_o
);

    typedef struct packed {
        vphase_e          ph;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t             s_d, s_q;
    logic             at_last;
    logic             load;
    logic [CNT_W-1:0] cnt_inc;

    always_comb begin
        unique case (s_q.ph)
            PH_LEAD:  at_last = (s_q.cnt == lead_last_i);
            PH_LINES: at_last = (s_q.cnt == lines_last_i);
            PH_TAIL:  at_last = (s_q.cnt == tail_last_i);
            PH_SYNC:  at_last = (s_q.cnt == sync_last_i);
            default:  at_last = 1'b1;
        endcase
    end

    assign cnt_inc = s_q.cnt + CNT_W'(1);

    always_comb begin
        s_d  = s_q;
        load = 1'b0;
        if (!en_i) begin
            // Parked at the frame start; configuration follows the inputs.
            load    = 1'b1;
            s_d.ph  = live_lead_zero_i ? PH_LINES : PH_LEAD;
            s_d.cnt = '0;
        end else begin
            unique case (s_q.ph)
                PH_LEAD: begin
                    if (lead_zero_i) begin
                        s_d.ph  = PH_LINES;
                        s_d.cnt = '0;
                    end else if (tick_i) begin
                        if (at_last) begin
                            s_d.ph  = PH_LINES;
                            s_d.cnt = '0;
                        end else begin
                            s_d.cnt = cnt_inc;
                        end
                    end
                end
                PH_LINES: begin
                    if (tick_i) begin
                        if (at_last) begin
                            s_d.ph  = tail_zero_i ? PH_SYNC : PH_TAIL;
                            s_d.cnt = '0;
                        end else begin
                            s_d.cnt = cnt_inc;
                        end
                    end
                end
                PH_TAIL: begin
                    if (tail_zero_i) begin
                        s_d.ph  = PH_SYNC;
                        s_d.cnt = '0;
                    end else if (tick_i) begin
                        if (at_last) begin
                            s_d.ph  = PH_SYNC;
                            s_d.cnt = '0;
                        end else begin
                            s_d.cnt = cnt_inc;
                        end
                    end
                end
                PH_SYNC: begin
                    if (tick_i) begin
                        if (at_last) begin
                            // Frame boundary: next frame uses fresh settings.
                            load    = 1'b1;
                            s_d.ph  = live_lead_zero_i ? PH_LINES : PH_LEAD;
                            s_d.cnt = '0;
                        end else begin
                            s_d.cnt = cnt_inc;
                        end
                    end
                end
                default: begin
                    s_d.ph  = PH_LEAD;
                    s_d.cnt = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{ph: PH_LEAD, cnt: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign phase_o     = s_q.ph;
    assign cnt_o       = s_q.cnt;
    assign phase_nxt_o = s_d.ph;
    assign cnt_nxt_o   = s_d.cnt;
    assign load_o      = load;

endmodule

// File: rtl/lcd_vframe_out.sv
// Output decode and frame marker pulses.
module lcd_vframe_out
    import lcd_vframe_pkg::*;
#(
    parameter int LINE_W = 10,
    parameter int CNT_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              tick_i,
    input  vphase_e           phase_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  vphase_e           phase_nxt_i,
    input  logic [CNT_W-1:0]  cnt_nxt_i,
    input  logic              act_mode_i,
    input  logic [CNT_W-1:0]  lines_last_i,
    output logic              frame_clk_o,
    output logic              line_valid_o,
    output logic [LINE_W-1:0] line_idx_o,
    output logic              sof_o,
    output logic              eof_o
);

    typedef struct packed {
        logic run;
        logic sof;
        logic eof;
    } mark_t;

    mark_t mk_d, mk_q;
    logic  first_now;
    logic  first_nxt;
    logic  in_lines;

    assign in_lines  = mk_q.run && (phase_i == PH_LINES);
    assign first_now = in_lines && (cnt_i == '0);
    assign first_nxt = (phase_nxt_i == PH_LINES) && (cnt_nxt_i == '0);

    always_comb begin
        mk_d     = mk_q;
        mk_d.run = en_i;
        mk_d.sof = en_i && first_nxt && !first_now;
        mk_d.eof = en_i && tick_i && (phase_i == PH_LINES) && (cnt_i == lines_last_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mk_q <= '0;
        end else begin
            mk_q <= mk_d;
        end
    end

    always_comb begin
        if (act_mode_i) begin
            frame_clk_o = mk_q.run && (phase_i == PH_SYNC);
        end else begin
            frame_clk_o = first_now;
        end
        line_valid_o = in_lines;
        line_idx_o   = in_lines ? cnt_i[LINE_W-1:0] : '0;
    end

    assign sof_o = mk_q.sof;
    assign eof_o = mk_q.eof;

endmodule

// File: rtl/lcd_vframe_seq.sv
// Top of the LCD vertical frame timing sequencer.
module lcd_vframe_seq
    import lcd_vframe_pkg::*;
#(
    parameter int WAIT_W = 8,
    parameter int SYNC_W = 6,
    parameter int LINE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              line_tick,
    input  logic              act_mode,
    input  logic [WAIT_W-1:0] bwait,
    input  logic [WAIT_W-1:0] ewait,
    input  logic [SYNC_W-1:0] sync_width,
    input  logic [LINE_W-1:0] lines,
    output logic              frame_clk,
    output logic              line_valid,
    output logic [LINE_W-1:0] line_idx,
    output logic              sof,
    output logic              eof
);

    localparam int WS_MAX = (WAIT_W > SYNC_W) ? WAIT_W : SYNC_W;
    localparam int CNT_W  = (LINE_W > WS_MAX) ? LINE_W : WS_MAX;

    logic             load;
    logic             live_lead_zero;
    logic             cur_act;
    logic             lead_zero;
    logic             tail_zero;
    logic [CNT_W-1:0] lead_last;
    logic [CNT_W-1:0] tail_last;
    logic [CNT_W-1:0] sync_last;
    logic [CNT_W-1:0] lines_last;
    vphase_e          phase;
    vphase_e          phase_nxt;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_nxt;

    lcd_vframe_cfg #(
        .WAIT_W (WAIT_W),
        .SYNC_W (SYNC_W),
        .LINE_W (LINE_W),
        .CNT_W  (CNT_W)
    ) i_cfg (
        .clk              (clk),
        .rst_n            (rst_n),
        .load_i           (load),
        .act_mode_i       (act_mode),
        .bwait_i          (bwait),
        .ewait_i          (ewait),
        .sync_i           (sync_width),
        .lines_i          (lines),
        .live_lead_zero_o (live_lead_zero),
        .act_mode_o       (cur_act),
        .lead_zero_o      (lead_zero),
        .tail_zero_o      (tail_zero),
        .lead_last_o      (lead_last),
        .tail_last_o      (tail_last),
        .sync_last_o      (sync_last),
        .lines_last_o     (lines_last)
    );

    lcd_vframe_ctrl #(
        .CNT_W (CNT_W)
    ) i_ctrl (
        .clk              (clk),
        .rst_n            (rst_n),
        .en_i             (en),
        .tick_i           (line_tick),
        .live_lead_zero_i (live_lead_zero),
        .lead_zero_i      (lead_zero),
        .tail_zero_i      (tail_zero),
        .lead_last_i      (lead_last),
        .tail_last_i      (tail_last),
        .sync_last_i      (sync_last),
        .lines_last_i     (lines_last),
        .phase_o          (phase),
        .cnt_o            (cnt),
        .phase_nxt_o      (phase_nxt),
        .cnt_nxt_o        (cnt_nxt),
        .load_o           (load)
    );

    lcd_vframe_out #(
        .LINE_W (LINE_W),
        .CNT_W  (CNT_W)
    ) i_out (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_i         (en),
        .tick_i       (line_tick),
        .phase_i      (phase),
        .cnt_i        (cnt),
        .phase_nxt_i  (phase_nxt),
        .cnt_nxt_i    (cnt_nxt),
        .act_mode_i   (cur_act),
        .lines_last_i (lines_last),
        .frame_clk_o  (frame_clk),
        .line_valid_o (line_valid),
        .line_idx_o   (line_idx),
        .sof_o        (sof),
        .eof_o        (eof)
    );

endmodule

// File: rtl/lcd_vframe_chk.sv
// Port-level property checker, bound to the sequencer top.
module lcd_vframe_chk #(
    parameter int LINE_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic              line_tick,
    input logic              frame_clk,
    input logic              line_valid,
    input logic [LINE_W-1:0] line_idx,
    input logic              sof,
    input logic              eof
);

    AST_SOF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) sof |=> !sof); // R6
    AST_SOF_ON_LINE0: assert property (@(posedge clk) disable iff (!rst_n) sof |-> (line_valid && line_idx == '0)); // R6
    AST_EOF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) eof |=> !eof); // R7
    AST_EOF_AFTER_LINES: assert property (@(posedge clk) disable iff (!rst_n) eof |-> !line_valid); // R7
    AST_IDX_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !line_valid |-> (line_idx == '0)); // R3
    AST_DISABLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !en |=> (!line_valid && !frame_clk && !sof && !eof)); // R9
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n) (en && !line_tick && line_valid) |=> (line_valid && $stable(line_idx))); // R10

endmodule

bind lcd_vframe_seq lcd_vframe_chk #(
    .LINE_W (LINE_W)
) i_lcd_vframe_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .line_tick  (line_tick),
    .frame_clk  (frame_clk),
    .line_valid (line_valid),
    .line_idx   (line_idx),
    .sof        (sof),
    .eof        (eof)
);

// File: tb/test_lcd_vframe_seq.sv
module test_lcd_vframe_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       line_tick = 1'b0;
    logic       act_mode = 1'b0;
    logic [7:0] bwait = '0;
    logic [7:0] ewait = '0;
    logic [5:0] sync_width = '0;
    logic [9:0] lines = '0;
    logic       frame_clk;
    logic       line_valid;
    logic [9:0] line_idx;
    logic       sof;
    logic       eof;

    int n_tests = 0;
    int n_fail  = 0;

    typedef struct packed {
        logic       fc;
        logic       lv;
        logic [9:0] idx;
        logic       sof;
        logic       eof;
    } obs_t;

    always #2.5 clk = ~clk;

    lcd_vframe_seq i_lcd_vframe_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .line_tick  (line_tick),
        .act_mode   (act_mode),
        .bwait      (bwait),
        .ewait      (ewait),
        .sync_width (sync_width),
        .lines      (lines),
        .frame_clk  (frame_clk),
        .line_valid (line_valid),
        .line_idx   (line_idx),
        .sof        (sof),
        .eof        (eof)
    );

    function automatic int frame_len(bit a, int b, int e, int s, int l);
        return (a ? b : 0) + (l + 1) + (a ? e : 0) + (s + 1);
    endfunction

    // Expected outputs for line period 'pos' of a frame (R1-style model).
    function automatic obs_t expect_at(int pos, bit a, int b, int e, int s, int l);
        obs_t r;
        int lb = a ? b : 0;
        int le = a ? e : 0;
        r = '0;
        if (pos < lb) begin
            r = '0;
        end else if (pos < lb + l + 1) begin
            r.lv  = 1'b1;
            r.idx = 10'(pos - lb);
            r.sof = (pos == lb);
            r.fc  = !a && (pos == lb);
        end else if (pos < lb + l + 1 + le) begin
            r.eof = (pos == lb + l + 1);
        end else begin
            r.fc  = a;
            r.eof = (pos == lb + l + 1);
        end
        return r;
    endfunction

    task automatic check(input obs_t exp, input string tag);
        obs_t got;
        got = '{fc: frame_clk, lv: line_valid, idx: line_idx, sof: sof, eof: eof};
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got fc=%0b lv=%0b idx=%0d sof=%0b eof=%0b expected fc=%0b lv=%0b idx=%0d sof=%0b eof=%0b",
                     tag, got.fc, got.lv, got.idx, got.sof, got.eof,
                     exp.fc, exp.lv, exp.idx, exp.sof, exp.eof);
        end
    endtask

    task automatic tick_once();
        @(negedge clk) line_tick = 1'b1;
        @(negedge clk) line_tick = 1'b0;
    endtask

    // Park, load the configuration, enable and check line period 0.
    task automatic start(input bit a, input int b, input int e, input int s, input int l, input string tag);
        @(negedge clk);
        en = 1'b0;
        act_mode = a; bwait = 8'(b); ewait = 8'(e); sync_width = 6'(s); lines = 10'(l);
        @(negedge clk);
        @(negedge clk) en = 1'b1;
        @(negedge clk);
        check(expect_at(0, a, b, e, s, l), tag);
    endtask

    // Advance 'count' line periods, starting at period from_pos.
    task automatic play(input bit a, input int b, input int e, input int s, input int l,
                        input int from_pos, input int count, input string tag);
        int f = frame_len(a, b, e, s, l);
        obs_t exp;
        for (int k = 0; k < count; k++) begin
            tick_once();
            check(expect_at((from_pos + k) % f, a, b, e, s, l), tag);
            @(negedge clk);
            exp = expect_at((from_pos + k) % f, a, b, e, s, l);
            exp.sof = 1'b0;
            exp.eof = 1'b0;
            check(exp, "R6/R7 pulse width");
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check('0, "R11 reset outputs");
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        check('0, "R11 idle after reset");
    endtask

    task automatic t_active_basic();
        start(1'b1, 2, 3, 1, 4, "R1 active start");
        play(1'b1, 2, 3, 1, 4, 1, 2 * frame_len(1'b1, 2, 3, 1, 4),
             "R1/R3/R4/R6/R7 active frames");
    endtask

    task automatic t_zero_waits();
        start(1'b1, 0, 0, 0, 2, "R2 zero-wait start");
        play(1'b1, 0, 0, 0, 2, 1, 3 * frame_len(1'b1, 0, 0, 0, 2), "R2/R4/R7 zero waits");
    endtask

    task automatic t_passive();
        start(1'b0, 5, 7, 2, 3, "R5 passive start");
        play(1'b0, 5, 7, 2, 3, 1, 2 * frame_len(1'b0, 5, 7, 2, 3), "R5 passive frames");
    endtask

    task automatic t_cfg_change();
        int fa = frame_len(1'b1, 1, 2, 0, 3);
        start(1'b1, 1, 2, 0, 3, "R8 cfg start");
        @(negedge clk);
        act_mode = 1'b1; bwait = 8'd0; ewait = 8'd1; sync_width = 6'd2; lines = 10'd1;
        play(1'b1, 1, 2, 0, 3, 1, fa - 1, "R8 old cfg kept in running frame");
        play(1'b1, 0, 1, 2, 1, 0, frame_len(1'b1, 0, 1, 2, 1) + 1, "R8 new cfg next frame");
    endtask

    task automatic t_disable();
        start(1'b1, 1, 1, 3, 2, "R9 pre-disable start");
        play(1'b1, 1, 1, 3, 2, 1, 6, "R9 run to sync");
        check(expect_at(6, 1'b1, 1, 1, 3, 2), "R4 sync high before disable");
        @(negedge clk) en = 1'b0;
        @(negedge clk);
        check('0, "R9 outputs low after disable");
        tick_once();
        check('0, "R9 tick ignored while disabled");
        start(1'b1, 1, 1, 3, 2, "R9 restart at frame start");
        play(1'b1, 1, 1, 3, 2, 1, frame_len(1'b1, 1, 1, 3, 2), "R9 frame after restart");
    endtask

    task automatic t_hold();
        obs_t exp;
        start(1'b1, 0, 0, 1, 5, "R10 hold start");
        play(1'b1, 0, 0, 1, 5, 1, 2, "R10 advance");
        exp = expect_at(2, 1'b1, 0, 0, 1, 5);
        exp.sof = 1'b0;
        exp.eof = 1'b0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            check(exp, "R10 no tick no move");
        end
        play(1'b1, 0, 0, 1, 5, 3, 5, "R10 resume");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_active_basic();
        t_zero_waits();
        t_passive();
        t_cfg_change();
        t_disable();
        t_hold();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule